// File: doc/BRIEF.md
# Change-Strobed Control and Stream Clock-Domain Bridge

This block moves two kinds of traffic into one consumer clock domain. One is a slowly varying control word, such as a gain setting. The other is a stream of data words. Each comes from its own producer clock, and each crosses in its own asynchronous FIFO. The three clocks (control, data producer, consumer) may be fully unrelated.

On the control side the producer has no write handshake. The block samples the control word on every control-clock edge. It writes the word into the control FIFO on the cycle where it differs from the previous sample. A word that stays unchanged therefore costs no FIFO traffic. On the data side the producer's valid signal is the write enable.

In the consumer domain each FIFO is read on every cycle in which it is not empty. Read data appears one consumer cycle after the read. The last control word read is held on the control output until the next one arrives. Each data word is presented for exactly one cycle, together with a valid pulse. The producers are trusted never to overrun a FIFO, so no full flag and no back-pressure exist.

Top module: `xdc_ctrl_stream_bridge`

## Requirements
- R1: On a control-clock edge, a control write happens exactly when `ctl_in` differs from its value at the previous control-clock edge. A change held for several cycles produces one write only. The written word is the new value.
- R2: After reset the change detector's previous sample equals `CTL_RESET`. `ctl_out` resets to `CTL_RESET` (default 8'h40). While `ctl_in` stays at `CTL_RESET`, no write occurs and `ctl_out` keeps its reset value.
- R3: Every data-clock edge with `din_valid` high writes `din`. Every written word leaves on `dout` exactly once, in write order.
- R4: `dout_valid` is high for one consumer cycle per delivered word, in the cycle after the data FIFO was read. It is never high unless the FIFO was non-empty in the previous consumer cycle. It is 0 in reset.
- R5: Every control write reaches `ctl_out` in write order. `ctl_out` changes only one consumer cycle after a control FIFO read, and it holds its value otherwise. Once input changes stop, `ctl_out` settles at the final `ctl_in` value.
- R6: Each FIFO's Gray-coded write and read pointers change in at most one bit per edge of their own clock.
- R7: `dout` holds its value in every consumer cycle that does not follow a data FIFO read.
- R8: Ordering and completeness (R3, R5) hold with all three clocks at unrelated periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control producer clock |
| ctl_rst_n | input | 1 | Active-low asynchronous reset, control domain |
| ctl_in | input | CTL_W | Control word from the control producer |
| dat_clk | input | 1 | Data producer clock |
| dat_rst_n | input | 1 | Active-low asynchronous reset, data domain |
| din | input | DATA_W | Data word from the data producer |
| din_valid | input | 1 | Data word qualifier, used as FIFO write enable |
| con_clk | input | 1 | Consumer clock |
| con_rst_n | input | 1 | Active-low asynchronous reset, consumer domain |
| ctl_out | output | CTL_W | Most recently delivered control word |
| dout | output | DATA_W | Delivered data word |
| dout_valid | output | 1 | One-cycle qualifier for `dout` |

## Verification
The properties assume three things about the inputs:
- Neither producer ever writes more words than its FIFO can hold ahead of the consumer.
- `ctl_in` holds `CTL_RESET` while reset is active.
- The resets release together from a common asserted state.

The stimulus respects these limits in two ways. The data clock runs slower than the consumer clock, so even back-to-back valid words drain faster than they arrive. Control changes are sparse random events plus a few directed back-to-back changes, so the control FIFO stays far from its depth. During reset the control input is held at its reset value and data valid is held low.

// File: rtl/xdc_pkg.sv
package xdc_pkg;

   // Lower bound on synchronizer depth for metastability settling.
   localparam int unsigned XDC_MIN_SYNC = 2;
   // Upper bound on pointer address width, keeps FIFO memory modest.
   localparam int unsigned XDC_MAX_AW   = 12;

   function automatic bit xdc_aw_ok(input int unsigned aw);
      return (aw >= 1) && (aw <= XDC_MAX_AW);
   endfunction

endpackage

// File: rtl/xdc_change_strobe.sv
module xdc_change_strobe #(
   parameter int unsigned    W       = 8,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] value,
   output logic         strobe
);

   logic [W-1:0] prev_q;

   // Previous sample starts at the input's reset value: no write out of reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= value;
   end

   assign strobe = (value != prev_q);

endmodule

// File: rtl/xdc_sync.sv
module xdc_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/xdc_async_fifo.sv
module xdc_async_fifo
   import xdc_pkg::*;
#(
   parameter int unsigned  W      = 16,
   parameter int unsigned  AW     = 4,
   parameter int unsigned  STAGES = 2,
   parameter logic [W-1:0] RD_RST = '0
) (
   input  logic         wr_clk,
   input  logic         wr_rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_clk,
   input  logic         rd_rst_n,
   output logic [W-1:0] rd_data,
   output logic         rd_empty
);

   localparam int unsigned DEPTH = 1 << AW;
   localparam int unsigned PW    = AW + 1;

   if (!xdc_aw_ok(AW)) begin : g_bad_aw
      $error("xdc_async_fifo: AW out of range");
   end
   if (STAGES < XDC_MIN_SYNC) begin : g_bad_sync
      $error("xdc_async_fifo: STAGES below minimum");
   end

   logic [W-1:0]  mem [DEPTH];

   // ---------------- write domain ----------------
   logic [PW-1:0] wr_bin, wr_gray, wr_bin_nxt;

   assign wr_bin_nxt = wr_bin + PW'(1);

   always_ff @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n) begin
         wr_bin  <= '0;
         wr_gray <= '0;
      end else if (wr_en) begin
         wr_bin  <= wr_bin_nxt;
         wr_gray <= wr_bin_nxt ^ (wr_bin_nxt >> 1);
      end
   end

   always_ff @(posedge wr_clk) begin
      if (wr_en) mem[wr_bin[AW-1:0]] <= wr_data;
   end

   // ---------------- crossing ----------------
   logic [PW-1:0] wr_gray_rd;

   xdc_sync #(.W(PW), .STAGES(STAGES)) u_wptr_sync (
      .clk   (rd_clk),
      .rst_n (rd_rst_n),
      .d     (wr_gray),
      .q     (wr_gray_rd)
   );

   // ---------------- read domain ----------------
   logic [PW-1:0] rd_bin, rd_gray, rd_bin_nxt;
   logic          rd_en;

   assign rd_empty   = (rd_gray == wr_gray_rd);
   assign rd_en      = !rd_empty;
   assign rd_bin_nxt = rd_bin + PW'(1);

   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) begin
         rd_bin  <= '0;
         rd_gray <= '0;
         rd_data <= RD_RST;
      end else if (rd_en) begin
         rd_bin  <= rd_bin_nxt;
         rd_gray <= rd_bin_nxt ^ (rd_bin_nxt >> 1);
         rd_data <= mem[rd_bin[AW-1:0]];
      end
   end

endmodule

// File: rtl/xdc_ctrl_stream_bridge.sv
module xdc_ctrl_stream_bridge
   import xdc_pkg::*;
#(
   parameter int unsigned        CTL_W       = 8,
   parameter int unsigned        DATA_W      = 16,
   parameter int unsigned        CTL_AW      = 3,
   parameter int unsigned        DATA_AW     = 4,
   parameter int unsigned        SYNC_STAGES = 2,
   parameter logic [CTL_W-1:0]   CTL_RESET   = CTL_W'(8'h40)
) (
   input  logic              ctl_clk,
   input  logic              ctl_rst_n,
   input  logic [CTL_W-1:0]  ctl_in,
   input  logic              dat_clk,
   input  logic              dat_rst_n,
   input  logic [DATA_W-1:0] din,
   input  logic              din_valid,
   input  logic              con_clk,
   input  logic              con_rst_n,
   output logic [CTL_W-1:0]  ctl_out,
   output logic [DATA_W-1:0] dout,
   output logic              dout_valid
);

   if (CTL_W < 1 || DATA_W < 1) begin : g_bad_w
      $error("xdc_ctrl_stream_bridge: widths must be positive");
   end

   logic ctl_wr;
   logic ctl_empty;
   logic dat_empty;

   // Control side: write only when the sampled word changes.
   xdc_change_strobe #(.W(CTL_W), .RST_VAL(CTL_RESET)) u_ctl_detect (
      .clk    (ctl_clk),
      .rst_n  (ctl_rst_n),
      .value  (ctl_in),
      .strobe (ctl_wr)
   );

   // Read register of the control FIFO doubles as the held output.
   xdc_async_fifo #(
      .W(CTL_W), .AW(CTL_AW), .STAGES(SYNC_STAGES), .RD_RST(CTL_RESET)
   ) u_ctl_fifo (
      .wr_clk   (ctl_clk),
      .wr_rst_n (ctl_rst_n),
      .wr_en    (ctl_wr),
      .wr_data  (ctl_in),
      .rd_clk   (con_clk),
      .rd_rst_n (con_rst_n),
      .rd_data  (ctl_out),
      .rd_empty (ctl_empty)
   );

   xdc_async_fifo #(
      .W(DATA_W), .AW(DATA_AW), .STAGES(SYNC_STAGES), .RD_RST('0)
   ) u_dat_fifo (
      .wr_clk   (dat_clk),
      .wr_rst_n (dat_rst_n),
      .wr_en    (din_valid),
      .wr_data  (din),
      .rd_clk   (con_clk),
      .rd_rst_n (con_rst_n),
      .rd_data  (dout),
      .rd_empty (dat_empty)
   );

   // Read is implied by non-empty; data appears one cycle later.
   always_ff @(posedge con_clk or negedge con_rst_n) begin
      if (!con_rst_n) dout_valid <= 1'b0;
      else            dout_valid <= !dat_empty;
   end

endmodule

// File: rtl/xdc_bridge_chk.sv
module xdc_bridge_chk #(
   parameter int unsigned      CTL_W     = 8,
   parameter int unsigned      DATA_W    = 16,
   parameter int unsigned      CTL_AW    = 3,
   parameter int unsigned      DATA_AW   = 4,
   parameter logic [CTL_W-1:0] CTL_RESET = '0
) (
   input logic              ctl_clk,
   input logic              ctl_rst_n,
   input logic [CTL_W-1:0]  ctl_in,
   input logic              ctl_wr,
   input logic              dat_clk,
   input logic              dat_rst_n,
   input logic              con_clk,
   input logic              con_rst_n,
   input logic [CTL_W-1:0]  ctl_out,
   input logic [DATA_W-1:0] dout,
   input logic              dout_valid,
   input logic              ctl_empty,
   input logic              dat_empty,
   input logic [CTL_AW:0]   ctl_wg,
   input logic [CTL_AW:0]   ctl_rg,
   input logic [DATA_AW:0]  dat_wg,
   input logic [DATA_AW:0]  dat_rg
);

   AST_ONE_WRITE_PER_CHANGE: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
      ctl_wr |=> (!ctl_wr || !$stable(ctl_in))); // R1

   AST_NO_IDLE_WRITE: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
      (ctl_in == CTL_RESET && $past(ctl_in) == CTL_RESET) |-> !ctl_wr); // R2

   AST_CTL_WPTR_GRAY: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
      $countones(ctl_wg ^ $past(ctl_wg)) <= 1); // R6

   AST_DAT_WPTR_GRAY: assert property (@(posedge dat_clk) disable iff (!dat_rst_n)
      $countones(dat_wg ^ $past(dat_wg)) <= 1); // R6

   AST_CTL_RPTR_GRAY: assert property (@(posedge con_clk) disable iff (!con_rst_n)
      $countones(ctl_rg ^ $past(ctl_rg)) <= 1); // R6

   AST_DAT_RPTR_GRAY: assert property (@(posedge con_clk) disable iff (!con_rst_n)
      $countones(dat_rg ^ $past(dat_rg)) <= 1); // R6

   AST_VALID_AFTER_READ: assert property (@(posedge con_clk) disable iff (!con_rst_n)
      dout_valid |-> $past(!dat_empty)); // R4

   AST_CTL_HOLD: assert property (@(posedge con_clk) disable iff (!con_rst_n)
      $past(ctl_empty) |-> $stable(ctl_out)); // R5

   AST_DOUT_HOLD: assert property (@(posedge con_clk) disable iff (!con_rst_n)
      $past(dat_empty) |-> $stable(dout)); // R7

endmodule

bind xdc_ctrl_stream_bridge xdc_bridge_chk #(
   .CTL_W(CTL_W), .DATA_W(DATA_W), .CTL_AW(CTL_AW), .DATA_AW(DATA_AW),
   .CTL_RESET(CTL_RESET)
) u_chk (
   .ctl_clk    (ctl_clk),
   .ctl_rst_n  (ctl_rst_n),
   .ctl_in     (ctl_in),
   .ctl_wr     (ctl_wr),
   .dat_clk    (dat_clk),
   .dat_rst_n  (dat_rst_n),
   .con_clk    (con_clk),
   .con_rst_n  (con_rst_n),
   .ctl_out    (ctl_out),
   .dout       (dout),
   .dout_valid (dout_valid),
   .ctl_empty  (ctl_empty),
   .dat_empty  (dat_empty),
   .ctl_wg     (u_ctl_fifo.wr_gray),
   .ctl_rg     (u_ctl_fifo.rd_gray),
   .dat_wg     (u_dat_fifo.wr_gray),
   .dat_rg     (u_dat_fifo.rd_gray)
);

// File: tb/tb_xdc_ctrl_stream_bridge.sv
`timescale 1ns/1ps
module tb_xdc_ctrl_stream_bridge;

   localparam int unsigned CW = 8;
   localparam int unsigned DW = 16;
   localparam logic [CW-1:0] RST_CTL = 8'h40;

   logic          ctl_clk = 0, dat_clk = 0, con_clk = 0;
   logic          rst_n = 0;
   logic [CW-1:0] ctl_in = RST_CTL;
   logic [DW-1:0] din = '0;
   logic          din_valid = 0;
   logic [CW-1:0] ctl_out;
   logic [DW-1:0] dout;
   logic          dout_valid;

   always #10 con_clk = ~con_clk;   // 50 MHz consumer
   always #8  ctl_clk = ~ctl_clk;
   always #15 dat_clk = ~dat_clk;   // slower than consumer: no overrun

   xdc_ctrl_stream_bridge dut (
      .ctl_clk(ctl_clk), .ctl_rst_n(rst_n), .ctl_in(ctl_in),
      .dat_clk(dat_clk), .dat_rst_n(rst_n), .din(din), .din_valid(din_valid),
      .con_clk(con_clk), .con_rst_n(rst_n),
      .ctl_out(ctl_out), .dout(dout), .dout_valid(dout_valid)
   );

   int n_vec = 0, n_bad = 0;
   logic [CW-1:0] ctl_q [$];
   logic [DW-1:0] dat_q [$];
   bit ctl_done = 0, dat_done = 0, mon_on = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
      end
   endtask

   // Bench model: a random control word guaranteed to differ from cur.
   function automatic logic [CW-1:0] pick_new(input logic [CW-1:0] cur);
      logic [CW-1:0] v;
      v = CW'($urandom);
      if (v == cur) v = cur ^ CW'(1);
      return v;
   endfunction

   // Control producer (R1, R2).
   task automatic ctl_change(input logic [CW-1:0] v);
      @(negedge ctl_clk);
      ctl_in = v;
      ctl_q.push_back(v);
   endtask

   initial begin : ctl_drv
      wait (rst_n);
      repeat (30) @(negedge ctl_clk);          // R2 idle window
      chk(ctl_out == RST_CTL, "R2 idle", 32'(ctl_out), 32'(RST_CTL));
      // back-to-back directed changes, including return to old value (R1)
      ctl_change(8'h11);
      ctl_change(8'h22);
      ctl_change(8'h11);
      repeat (3) @(negedge ctl_clk);
      ctl_change(RST_CTL);                     // returning to reset value is a change
      ctl_change(8'hFF);
      for (int i = 0; i < 1500; i++) begin
         if ($urandom_range(0, 7) == 0) ctl_change(pick_new(ctl_in));
         else @(negedge ctl_clk);
      end
      ctl_done = 1;
   end

   // Data producer (R3).
   initial begin : dat_drv
      wait (rst_n);
      repeat (5) @(negedge dat_clk);
      for (int i = 0; i < 12; i++) begin       // directed burst, all valid
         @(negedge dat_clk);
         din = DW'(16'hA000 + i); din_valid = 1; dat_q.push_back(din);
      end
      @(negedge dat_clk); din_valid = 0;
      for (int i = 0; i < 1500; i++) begin
         @(negedge dat_clk);
         din_valid = $urandom_range(0, 1) == 1;
         din = DW'($urandom);
         if (din_valid) dat_q.push_back(din);
      end
      @(negedge dat_clk); din_valid = 0;
      dat_done = 1;
   end

   // Consumer monitor, sampled on the inactive edge.
   logic [CW-1:0] last_ctl;
   logic [DW-1:0] last_dout;
   initial begin : mon
      wait (mon_on);
      last_ctl  = ctl_out;
      last_dout = dout;
      forever begin
         @(negedge con_clk);
         if (dout_valid) begin
            if (dat_q.size() == 0) chk(0, "R4 valid without word", 32'(dout), 0);
            else begin
               logic [DW-1:0] e;
               e = dat_q.pop_front();
               chk(dout == e, "R3 order", 32'(dout), 32'(e));
            end
         end else begin
            chk(dout == last_dout, "R7 hold", 32'(dout), 32'(last_dout));
         end
         last_dout = dout;
         if (ctl_out != last_ctl) begin
            if (ctl_q.size() == 0) chk(0, "R5 spurious ctl", 32'(ctl_out), 32'(last_ctl));
            else begin
               logic [CW-1:0] e;
               e = ctl_q.pop_front();
               chk(ctl_out == e, "R5 ctl order", 32'(ctl_out), 32'(e));
            end
            last_ctl = ctl_out;
         end
      end
   end

   initial begin : main
      void'($urandom(32'd4242));
      fork
         begin
            repeat (5) @(negedge con_clk);
            chk(ctl_out == RST_CTL, "R2 reset ctl_out", 32'(ctl_out), 32'(RST_CTL));
            chk(dout_valid == 0, "R4 reset valid", 32'(dout_valid), 0);
            rst_n = 1;
            mon_on = 1;
            wait (ctl_done && dat_done);
            repeat (100) @(negedge con_clk);
            chk(dat_q.size() == 0, "R3 R8 all data delivered", dat_q.size(), 0);
            chk(ctl_q.size() == 0, "R5 R8 all ctl delivered", ctl_q.size(), 0);
            chk(ctl_out == ctl_in, "R5 final ctl", 32'(ctl_out), 32'(ctl_in));
            chk(dout_valid == 0, "R4 idle valid", 32'(dout_valid), 0);
         end
         begin
            repeat (150000) @(posedge con_clk);
            chk(0, "watchdog", 0, 1);
         end
      join_any
      disable fork;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule